// File: doc/BRIEF.md
# Channel Fault Protection Supervisor

This block watches over eight power output channels and decides when they must be switched off. Each channel has its own overcurrent comparator bit. A pulse on that bit is ignored until it has stayed high for a programmable number of system clocks. Once that happens, the channel's kill bit is set and stays set.

The bits are held until a rising edge on the synchronised enable/reset input, or until the supply drops into lockout. A temperature code and a supply-voltage code each pass through a threshold stage with hysteresis. Over-temperature turns every channel off without being latched. Undervoltage turns every channel off as though the enable/reset input were held high.

The block produces three outputs: the per-channel kill mask, a global disable and an active-low fault flag. The output stage combines these with its own latch data.

Top module: `fault_supervisor`

## Requirements
- R1: An overload on one channel sets only that channel's kill bit, where bit i of `kill_mask` belongs to bit i of `oc_raw`; other bits stay 0.
- R2: A channel's comparator bit must be high for `FILT_CYC` consecutive clocks (default 100, which is 2 µs at 50 MHz) before its kill bit is set. A run of `FILT_CYC`-1 clocks or less leaves the kill bit at 0, and any low clock restarts the count.
- R3: A set kill bit stays 1 after the comparator bit returns low. It is cleared only by reset, an enable/reset rising edge or undervoltage.
- R4: A rising edge on the synchronised `oe_rst_in` clears every kill bit. A clear takes priority over a trip in the same cycle and restarts the filter, so a channel that is still overloaded trips again only after a further `FILT_CYC` clocks.
- R5: A temperature code above 165 raises `global_off` and drives `fault_n` low. Both stay that way until the code is 155 or lower, and the condition clears without any reset pulse.
- R6: After reset the block is in lockout (`global_off`=1). Lockout is released when `vdd_code` (in 10 mV units) reaches 450 or more, and engaged again at 300 or less. Values in between keep the present state. While in lockout, all kill bits are held at 0.
- R7: While the synchronised `oe_rst_in` is high, `global_off` is 1.
- R8: `fault_n` is 0 whenever any kill bit is set or the over-temperature condition is active. Undervoltage alone leaves it at 1.
- R9: During and right after reset, `kill_mask` is 0, `fault_n` is 1 and `global_off` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| oc_raw | input | NCH | Per-channel overcurrent comparator bits (asynchronous) |
| temp_code | input | TEMP_W | Die temperature, unsigned, in °C |
| vdd_code | input | VDD_W | Logic supply, unsigned, in 10 mV units |
| oe_rst_in | input | 1 | Enable/reset input; high disables outputs, a rising edge clears latched faults |
| kill_mask | output | NCH | Per-channel off command from latched overcurrent faults |
| global_off | output | 1 | All-channel disable (over-temperature, lockout or enable/reset high) |
| fault_n | output | 1 | Active-low fault flag |

## Verification
A latched-fault clear and a filter trip can fall into the same cycle. This happens when a channel stays overloaded across an enable/reset pulse. The bench holds a comparator bit high and pulses `oe_rst_in`. It expects the kill bit to drop within a few clocks and to return only after a complete new filter window. Over-temperature and a latched overcurrent can also be active together. The bench judges this case at the flag, which must stay low until both causes have gone.

// File: rtl/fsup_pkg.sv
package fsup_pkg;
  typedef enum logic {
    HYST_SET_ABOVE = 1'b0,
    HYST_SET_BELOW = 1'b1
  } hyst_dir_e;
endpackage

// File: rtl/fsup_sync.sv
module fsup_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) stage[i] <= '0;
    end else begin
      stage[0] <= d;
      for (int i = 1; i < STAGES; i++) stage[i] <= stage[i-1];
    end
  end

  assign q = stage[STAGES-1];
endmodule

// File: rtl/fsup_hyst.sv
module fsup_hyst
  import fsup_pkg::*;
#(
  parameter int        W       = 8,
  parameter hyst_dir_e DIR     = HYST_SET_ABOVE,
  parameter int        SET_LVL = 165,
  parameter int        CLR_LVL = 155,
  parameter logic      RST_VAL = 1'b0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] code,
  output logic         active
);
  logic set_c, clr_c;

  generate
    if (DIR == HYST_SET_ABOVE) begin : g_above
      assign set_c = code >  W'(SET_LVL);
      assign clr_c = code <= W'(CLR_LVL);
    end else begin : g_below
      assign set_c = code <= W'(SET_LVL);
      assign clr_c = code >= W'(CLR_LVL);
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst)        active <= RST_VAL;
    else if (set_c) active <= 1'b1;
    else if (clr_c) active <= 1'b0;
  end
endmodule

// File: rtl/fsup_filt_latch.sv
module fsup_filt_latch #(
  parameter int FILT_CYC = 100
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic oc,
  output logic tripped
);
  localparam int CW = $clog2(FILT_CYC + 1);
  localparam logic [CW-1:0] LAST = CW'(FILT_CYC - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt     <= '0;
      tripped <= 1'b0;
    end else if (!oc) begin
      cnt <= '0;
    end else if (cnt == LAST) begin
      tripped <= 1'b1;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/fault_supervisor.sv
module fault_supervisor
  import fsup_pkg::*;
#(
  parameter int NCH       = 8,
  parameter int FILT_CYC  = 100,
  parameter int SYNC_LEN  = 2,
  parameter int TEMP_W    = 8,
  parameter int TEMP_TRIP = 165,
  parameter int TEMP_CLR  = 155,
  parameter int VDD_W     = 10,
  parameter int VDD_ENG   = 300,
  parameter int VDD_REL   = 450
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NCH-1:0]    oc_raw,
  input  logic [TEMP_W-1:0] temp_code,
  input  logic [VDD_W-1:0]  vdd_code,
  input  logic              oe_rst_in,
  output logic [NCH-1:0]    kill_mask,
  output logic              global_off,
  output logic              fault_n
);
  logic [NCH-1:0] oc_s;
  logic           oe_s, oe_d, oe_rise;
  logic           hot_q, uv_q, clr_all;

  fsup_sync #(.W(NCH), .STAGES(SYNC_LEN)) u_oc_sync (
    .clk(clk), .rst(rst), .d(oc_raw), .q(oc_s));

  fsup_sync #(.W(1), .STAGES(SYNC_LEN)) u_oe_sync (
    .clk(clk), .rst(rst), .d(oe_rst_in), .q(oe_s));

  always_ff @(posedge clk) begin
    if (rst) oe_d <= 1'b0;
    else     oe_d <= oe_s;
  end

  assign oe_rise = oe_s & ~oe_d;
  assign clr_all = oe_rise | uv_q;

  fsup_hyst #(.W(TEMP_W), .DIR(HYST_SET_ABOVE), .SET_LVL(TEMP_TRIP),
              .CLR_LVL(TEMP_CLR), .RST_VAL(1'b0)) u_temp (
    .clk(clk), .rst(rst), .code(temp_code), .active(hot_q));

  fsup_hyst #(.W(VDD_W), .DIR(HYST_SET_BELOW), .SET_LVL(VDD_ENG),
              .CLR_LVL(VDD_REL), .RST_VAL(1'b1)) u_vdd (
    .clk(clk), .rst(rst), .code(vdd_code), .active(uv_q));

  for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
    fsup_filt_latch #(.FILT_CYC(FILT_CYC)) u_filt (
      .clk(clk), .rst(rst), .clr(clr_all), .oc(oc_s[ch]),
      .tripped(kill_mask[ch]));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      global_off <= 1'b1;
      fault_n    <= 1'b1;
    end else begin
      global_off <= hot_q | uv_q | oe_s;
      fault_n    <= ~((|kill_mask) | hot_q);
    end
  end
endmodule

// File: rtl/fsup_chk.sv
module fsup_chk #(
  parameter int NCH       = 8,
  parameter int FILT_CYC  = 100,
  parameter int TEMP_W    = 8,
  parameter int TEMP_TRIP = 165
) (
  input logic              clk,
  input logic              rst,
  input logic [NCH-1:0]    oc_s,
  input logic [NCH-1:0]    kill_mask,
  input logic [TEMP_W-1:0] temp_code,
  input logic              fault_n,
  input logic              global_off,
  input logic              uv_q,
  input logic              clr_all
);
  localparam int CW = $clog2(FILT_CYC + 1);

  for (genvar ch = 0; ch < NCH; ch++) begin : g_run
    logic [CW-1:0] run;
    always_ff @(posedge clk) begin
      if (rst || !oc_s[ch])              run <= '0;
      else if (run != CW'(FILT_CYC))     run <= run + 1'b1;
    end
    // R2: a kill bit rises only after a full window of comparator highs
    a_r2_full_window: assert property (@(posedge clk) disable iff (rst)
      $rose(kill_mask[ch]) |-> (run == CW'(FILT_CYC)));
  end

  a_r3_sticky_kill: assert property (@(posedge clk) disable iff (rst)
    (|($past(kill_mask) & ~kill_mask)) |-> ($past(clr_all) || $past(rst)));

  a_r5_hot_disables: assert property (@(posedge clk) disable iff (rst)
    (temp_code > TEMP_W'(TEMP_TRIP)) |=> ##1 (global_off && !fault_n));

  a_r6_lockout_off: assert property (@(posedge clk) disable iff (rst)
    uv_q |=> global_off);

  a_r6_lockout_clears: assert property (@(posedge clk) disable iff (rst)
    $past(uv_q) |-> (kill_mask == '0));

  a_r8_kill_flags: assert property (@(posedge clk) disable iff (rst)
    (|kill_mask) |=> !fault_n);
endmodule

bind fault_supervisor fsup_chk #(
  .NCH(NCH), .FILT_CYC(FILT_CYC), .TEMP_W(TEMP_W), .TEMP_TRIP(TEMP_TRIP)
) u_chk (
  .clk(clk), .rst(rst), .oc_s(oc_s), .kill_mask(kill_mask),
  .temp_code(temp_code), .fault_n(fault_n), .global_off(global_off),
  .uv_q(uv_q), .clr_all(clr_all)
);

// File: tb/fault_supervisor_tb.sv
module fault_supervisor_tb;
  localparam int NCH  = 8;
  localparam int FILT = 100;
  localparam int TCLK = 20;

  logic           clk = 1'b0;
  logic           rst;
  logic [NCH-1:0] oc_raw;
  logic [7:0]     temp_code;
  logic [9:0]     vdd_code;
  logic           oe_rst_in;
  logic [NCH-1:0] kill_mask;
  logic           global_off, fault_n;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #(TCLK/2) clk = ~clk;

  fault_supervisor u_dut (
    .clk(clk), .rst(rst), .oc_raw(oc_raw), .temp_code(temp_code),
    .vdd_code(vdd_code), .oe_rst_in(oe_rst_in), .kill_mask(kill_mask),
    .global_off(global_off), .fault_n(fault_n));

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic bit hot_next(input bit cur, input logic [7:0] t);
    if (t > 8'd165)       return 1'b1;
    else if (t <= 8'd155) return 1'b0;
    else                  return cur;
  endfunction

  task automatic pulse_oe(input int len);
    oe_rst_in = 1'b1;
    tick(len);
    oe_rst_in = 1'b0;
    tick(6);
  endtask

  initial begin
    #(TCLK * 200000);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    bit hq1, hq2, hn;
    logic [7:0] t;
    void'($urandom(32'd4711));
    rst = 1'b1; oc_raw = '0; temp_code = 8'd25; vdd_code = 10'd0; oe_rst_in = 1'b0;
    tick(3);
    chk("R9 kill", kill_mask, 0);
    chk("R9 flag", fault_n, 1);
    chk("R9 goff", global_off, 1);
    rst = 1'b0;
    tick(1);
    chk("R9 kill after release", kill_mask, 0);

    // R6 lockout hysteresis
    vdd_code = 10'd400; tick(5); chk("R6 below release", global_off, 1);
    vdd_code = 10'd450; tick(4); chk("R6 release at 450", global_off, 0);
    chk("R8 no flag from lockout", fault_n, 1);
    vdd_code = 10'd350; tick(4); chk("R6 hold above 300", global_off, 0);
    vdd_code = 10'd300; tick(4); chk("R6 engage at 300", global_off, 1);
    chk("R8 lockout leaves flag", fault_n, 1);
    vdd_code = 10'd500; tick(4); chk("R6 release again", global_off, 0);

    // R2 short pulse, then full window on channel 2 (R1)
    oc_raw = 8'h04; tick(FILT - 1); oc_raw = '0; tick(6);
    chk("R2 short pulse ignored", kill_mask, 0);
    chk("R2 flag after short pulse", fault_n, 1);
    oc_raw = 8'h04; tick(FILT); oc_raw = '0; tick(5);
    chk("R1 only channel 2", kill_mask, 8'h04);
    chk("R8 flag on kill", fault_n, 0);
    tick(20);
    chk("R3 latched after drop", kill_mask, 8'h04);
    chk("R3 no global off", global_off, 0);

    // R7 and R4
    oe_rst_in = 1'b1; tick(4);
    chk("R7 oe high disables", global_off, 1);
    oe_rst_in = 1'b0; tick(6);
    chk("R4 cleared by oe edge", kill_mask, 0);
    chk("R4 flag released", fault_n, 1);
    chk("R7 goff released", global_off, 0);

    // R4 clear against held overload
    oc_raw = 8'h20; tick(FILT + 5);
    chk("R1 channel 5", kill_mask, 8'h20);
    pulse_oe(2);
    chk("R4 clear wins over held trip", kill_mask, 0);
    tick(FILT - 12);
    chk("R4 filter restarted", kill_mask, 0);
    tick(12);
    chk("R4 retrip after window", kill_mask, 8'h20);
    oc_raw = '0; pulse_oe(2);
    chk("R4 cleared again", kill_mask, 0);

    // R1 two channels, then R6 lockout clears
    oc_raw = 8'h81; tick(FILT + 4); oc_raw = '0; tick(4);
    chk("R1 two channels", kill_mask, 8'h81);
    vdd_code = 10'd250; tick(5);
    chk("R6 lockout clears kills", kill_mask, 0);
    chk("R6 lockout goff", global_off, 1);
    vdd_code = 10'd500; tick(5);

    // R5 thermal with hysteresis
    temp_code = 8'd165; tick(4); chk("R5 165 no trip", fault_n, 1);
    temp_code = 8'd166; tick(4); chk("R5 trip goff", global_off, 1);
    chk("R5 trip flag", fault_n, 0);
    temp_code = 8'd160; tick(4); chk("R5 hold at 160", fault_n, 0);
    temp_code = 8'd155; tick(4); chk("R5 clear at 155", fault_n, 1);
    chk("R5 goff cleared", global_off, 0);

    // R8/R5 thermal and latched kill overlapping
    oc_raw = 8'h10; tick(FILT + 4); oc_raw = '0;
    temp_code = 8'd170; tick(4);
    temp_code = 8'd100; tick(4);
    chk("R8 flag held by kill after cool", fault_n, 0);
    pulse_oe(2);
    chk("R8 flag free when both gone", fault_n, 1);

    // R5 random temperatures against bench model
    temp_code = 8'd100; tick(4);
    hq1 = 1'b0; hq2 = 1'b0;
    for (int i = 0; i < 400; i++) begin
      chk("R5 random goff", global_off, hq2);
      chk("R5 random flag", fault_n, !hq2);
      t = 8'(145 + ($urandom % 30));
      temp_code = t;
      hn = hot_next(hq1, t);
      hq2 = hq1; hq1 = hn;
      tick(1);
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule